// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and takes the memory from power-up to normal operation. Once a start input reports that supplies and clock are stable, it holds the clock-enable pin low for a power-up delay. It then raises clock enable and issues a fixed series of precharge, mode-register-load and auto-refresh commands on the command, bank and address pins. It spaces these commands by parameterized minimum gaps.

The delay length comes from the clock frequency in MHz multiplied by the required delay in microseconds. The command gaps tRP, tMRD and tRFC are counts of clock cycles. The base and extended mode register values are parameters. The DLL-reset flag is set in the first base-register load and cleared in the final one.

A done level rises when the sequence is complete, no earlier than the DLL lock window after the DLL-reset command. Done then stays high until reset. Between commands and after done, the bus carries NOP.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset, cke is low and the command bus {cs_n,ras_n,cas_n,we_n} carries NOP = 4'b0111. It stays this way while start is low. After start is sampled high in the idle state, this holds for CLK_MHZ*PWRUP_US more cycles (P). Start is ignored once the sequence has begun.
- R2: In cycle P+1 after start is sampled, cke goes high with a NOP on the bus. It stays high until reset.
- R3: One cycle after cke rises, a PRECHARGE ALL is issued: bus 4'b0010 with addr[10]=1.
- R4: T_RP cycles after the first precharge, a LOAD MODE REGISTER (4'b0000) is issued to the extended register: ba=2'b01, addr=EMR_VAL.
- R5: T_MRD cycles later, a LOAD MODE REGISTER is issued to the base register: ba=2'b00, addr=MR_VAL with bit DLL_RST_BIT set.
- R6: T_MRD cycles after the DLL-reset load, a second PRECHARGE ALL is issued (4'b0010, addr[10]=1).
- R7: T_RP cycles after the second precharge, an AUTO REFRESH (4'b0001) is issued. A second AUTO REFRESH follows T_RFC cycles after the first.
- R8: T_RFC cycles after the second refresh, a LOAD MODE REGISTER is issued to the base register: ba=2'b00, addr=MR_VAL with bit DLL_RST_BIT cleared.
- R9: Done rises in cycle max(final load + T_MRD, DLL-reset load + DLL_LOCK) and stays high until reset. Every command lasts exactly one cycle. Every other cycle, including all cycles after done, carries NOP.
- R10: Asserting rst_n low at any point returns the block at once to the R1 state: cke low, done low, NOP. The next start reruns the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Supplies and clock stable; sampled in idle only |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address; selects the mode register in loads |
| addr | output | ROW_W | Address; mode value in loads, addr[10] all-banks flag in precharge |
| done | output | 1 | Initialization complete, held until reset |

## Verification
The assertions assume that reset is applied before any check matters. They also assume that start is a level the block may sample at any edge. Their cycle windows count from the most recent reset, so they never look before it. The stimulus keeps to this. It always pulses reset for several cycles before a run, raises start only at a falling clock edge, and drops it one cycle later. It also aborts runs by reset both before and after done, so restarts and the late-start idle wait are covered without leaving the assumed input behaviour.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int CLK_MHZ     = 200,
  parameter int PWRUP_US    = 200,
  parameter int T_RP        = 3,
  parameter int T_MRD       = 2,
  parameter int T_RFC       = 14,
  parameter int DLL_LOCK    = 200,
  parameter int ROW_W       = 13,
  parameter int BA_W        = 2,
  parameter int DLL_RST_BIT = 8,
  parameter logic [ROW_W-1:0] EMR_VAL = '0,
  parameter logic [ROW_W-1:0] MR_VAL  = 13'h062
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             cke,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr,
  output logic             done
);
  localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;
  localparam int M1 = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int M2 = (M1 > T_RFC) ? M1 : T_RFC;
  localparam int MAXSPAN = (M2 > PWRUP_CYC) ? M2 : PWRUP_CYC;
  localparam int CNT_W = $clog2(MAXSPAN + 1);
  localparam int DLL_W = $clog2(DLL_LOCK + 1);
  localparam logic [ROW_W-1:0] DLL_MASK = ROW_W'(1) << DLL_RST_BIT;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_CKE, S_PRE1, S_EMR, S_MRR,
    S_PRE2, S_REF1, S_REF2, S_MRN, S_DLL, S_DONE
  } st_t;

  st_t st, st_nx;
  logic [CNT_W-1:0] cnt, span;
  logic [DLL_W-1:0] dll_cnt;
  logic [3:0] cmd;
  logic last, dll_ok, issue;

  always_comb begin
    case (st)
      S_PWR:          span = CNT_W'(PWRUP_CYC);
      S_PRE1, S_PRE2: span = CNT_W'(T_RP);
      S_EMR, S_MRR,
      S_MRN:          span = CNT_W'(T_MRD);
      S_REF1, S_REF2: span = CNT_W'(T_RFC);
      default:        span = CNT_W'(1);
    endcase
  end

  assign last   = (cnt == span - 1'b1);
  assign dll_ok = (dll_cnt >= DLL_W'(DLL_LOCK - 1));
  assign issue  = (cnt == '0);

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (start) st_nx = S_PWR;
      S_PWR:  if (last) st_nx = S_CKE;
      S_CKE:  if (last) st_nx = S_PRE1;
      S_PRE1: if (last) st_nx = S_EMR;
      S_EMR:  if (last) st_nx = S_MRR;
      S_MRR:  if (last) st_nx = S_PRE2;
      S_PRE2: if (last) st_nx = S_REF1;
      S_REF1: if (last) st_nx = S_REF2;
      S_REF2: if (last) st_nx = S_MRN;
      S_MRN:  if (last) st_nx = dll_ok ? S_DONE : S_DLL;
      S_DLL:  if (dll_ok) st_nx = S_DONE;
      default: st_nx = st;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      dll_cnt <= '0;
    end else begin
      st <= st_nx;
      if (st_nx != st) cnt <= '0;
      else if (!last)  cnt <= cnt + 1'b1;
      if (st == S_MRR && issue) dll_cnt <= DLL_W'(1);
      else if (dll_cnt != '0 && dll_cnt < DLL_W'(DLL_LOCK)) dll_cnt <= dll_cnt + 1'b1;
    end
  end

  always_comb begin
    cmd  = C_NOP;
    ba   = '0;
    addr = '0;
    if (issue) begin
      case (st)
        S_PRE1, S_PRE2: begin cmd = C_PRE; addr[10] = 1'b1; end
        S_EMR:          begin cmd = C_LMR; ba = BA_W'(1); addr = EMR_VAL; end
        S_MRR:          begin cmd = C_LMR; addr = MR_VAL | DLL_MASK; end
        S_REF1, S_REF2: cmd = C_REF;
        S_MRN:          begin cmd = C_LMR; addr = MR_VAL & ~DLL_MASK; end
        default:        cmd = C_NOP;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke  = (st != S_IDLE) && (st != S_PWR);
  assign done = (st == S_DONE);
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int CLK_MHZ     = 200,
  parameter int PWRUP_US    = 200,
  parameter int DLL_LOCK    = 200,
  parameter int ROW_W       = 13,
  parameter int BA_W        = 2,
  parameter int DLL_RST_BIT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [BA_W-1:0]  ba,
  input logic [ROW_W-1:0] addr,
  input logic             done
);
  localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;
  localparam int LW = $clog2(PWRUP_CYC + 1);
  localparam int DW = $clog2(DLL_LOCK + 1);

  logic [3:0] cmd;
  logic [LW-1:0] low_cnt;
  logic [DW-1:0] dcnt;
  logic dll_rst_cmd;

  assign cmd = {cs_n, ras_n, cas_n, we_n};
  assign dll_rst_cmd = (cmd == 4'b0000) && (ba == '0) && addr[DLL_RST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      dcnt    <= '0;
    end else begin
      if (!cke && low_cnt < LW'(PWRUP_CYC)) low_cnt <= low_cnt + 1'b1;
      if (dll_rst_cmd) dcnt <= DW'(1);
      else if (dcnt != '0 && dcnt < DW'(DLL_LOCK)) dcnt <= dcnt + 1'b1;
    end
  end

  AST_NOP_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !cke |-> cmd == 4'b0111); // R1
  AST_PWRUP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(cke) |-> low_cnt >= LW'(PWRUP_CYC)); // R1
  AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) cke |=> cke); // R2
  AST_NOP_ON_CKE_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(cke) |-> cmd == 4'b0111); // R2
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n) cmd == 4'b0010 |-> addr[10]); // R3
  AST_LMR_BANK_SELECT: assert property (@(posedge clk) disable iff (!rst_n) cmd == 4'b0000 |-> ba[BA_W-1:1] == '0); // R4
  AST_DLL_LOCK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> dcnt >= DW'(DLL_LOCK)); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done |=> done); // R9
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> cmd == 4'b0111); // R9
endmodule

bind ddr_init_seq ddr_init_seq_chk #(
  .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .DLL_LOCK(DLL_LOCK),
  .ROW_W(ROW_W), .BA_W(BA_W), .DLL_RST_BIT(DLL_RST_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .done(done)
);

// File: tb/sim_ddr_init_seq.sv
module sim_ddr_init_seq;
  localparam int CLK_NS = 10;
  localparam int MHZ[2]  = '{1, 2};
  localparam int US[2]   = '{5, 3};
  localparam int RP[2]   = '{3, 2};
  localparam int MRD[2]  = '{2, 4};
  localparam int RFC[2]  = '{7, 5};
  localparam int DLL[2]  = '{200, 18};
  localparam logic [12:0] EMRV[2] = '{13'h0000, 13'h0002};
  localparam logic [12:0] MRV[2]  = '{13'h0062, 13'h0029};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic cke0, cs0, ras0, cas0, we0, done0, cke1, cs1, ras1, cas1, we1, done1;
  logic [1:0] ba0, ba1;
  logic [12:0] ad0, ad1;
  logic [20:0] o [2];
  assign o[0] = {cke0, cs0, ras0, cas0, we0, ba0, ad0, done0};
  assign o[1] = {cke1, cs1, ras1, cas1, we1, ba1, ad1, done1};

  ddr_init_seq #(.CLK_MHZ(MHZ[0]), .PWRUP_US(US[0]), .T_RP(RP[0]), .T_MRD(MRD[0]),
    .T_RFC(RFC[0]), .DLL_LOCK(DLL[0]), .EMR_VAL(EMRV[0]), .MR_VAL(MRV[0])) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cke(cke0), .cs_n(cs0), .ras_n(ras0),
    .cas_n(cas0), .we_n(we0), .ba(ba0), .addr(ad0), .done(done0));

  ddr_init_seq #(.CLK_MHZ(MHZ[1]), .PWRUP_US(US[1]), .T_RP(RP[1]), .T_MRD(MRD[1]),
    .T_RFC(RFC[1]), .DLL_LOCK(DLL[1]), .EMR_VAL(EMRV[1]), .MR_VAL(MRV[1])) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .cke(cke1), .cs_n(cs1), .ras_n(ras1),
    .cas_n(cas1), .we_n(we1), .ba(ba1), .addr(ad1), .done(done1));

  int checks = 0, errors = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int when(int i, int k);
    int t[8];
    t[0] = MHZ[i]*US[i] + 2;
    t[1] = t[0] + RP[i];
    t[2] = t[1] + MRD[i];
    t[3] = t[2] + MRD[i];
    t[4] = t[3] + RP[i];
    t[5] = t[4] + RFC[i];
    t[6] = t[5] + RFC[i];
    t[7] = (t[6] + MRD[i] > t[2] + DLL[i]) ? t[6] + MRD[i] : t[2] + DLL[i];
    return t[k];
  endfunction

  task automatic idle_check(int i, string req);
    chk(o[i][20] == 1'b0, req, "cke", 32'(o[i][20]), 0);
    chk(o[i][0] == 1'b0, req, "done", 32'(o[i][0]), 0);
    chk(o[i][19:16] == 4'b0111, req, "cmd", 32'(o[i][19:16]), 32'h7);
  endtask

  task automatic cycle_check(int i, int n);
    logic [3:0] ec; logic [1:0] eb; logic [12:0] ea; string rq; int k;
    bit full = 1'b1;
    int p = MHZ[i]*US[i];
    chk(o[i][20] == (n >= p+1), (n >= p+1) ? "R2" : "R1", "cke", 32'(o[i][20]), 32'(n >= p+1));
    chk(o[i][0] == (n >= when(i,7)), "R9", "done", 32'(o[i][0]), 32'(n >= when(i,7)));
    k = -1;
    for (int j = 0; j < 7; j++) if (when(i,j) == n) k = j;
    ec = 4'b0111; eb = 2'b00; ea = '0; rq = (n <= p) ? "R1" : "R9";
    case (k)
      0: begin ec = 4'b0010; rq = "R3"; full = 1'b0; end
      1: begin ec = 4'b0000; eb = 2'b01; ea = EMRV[i]; rq = "R4"; end
      2: begin ec = 4'b0000; ea = MRV[i] | 13'h100; rq = "R5"; end
      3: begin ec = 4'b0010; rq = "R6"; full = 1'b0; end
      4: begin ec = 4'b0001; rq = "R7"; full = 1'b0; end
      5: begin ec = 4'b0001; rq = "R7"; full = 1'b0; end
      6: begin ec = 4'b0000; ea = MRV[i] & ~13'h100; rq = "R8"; end
      default: full = 1'b0;
    endcase
    chk(o[i][19:16] == ec, rq, $sformatf("cmd u%0d n%0d", i, n), 32'(o[i][19:16]), 32'(ec));
    if (ec == 4'b0010) chk(o[i][11] == 1'b1, rq, "addr10", 32'(o[i][11]), 1);
    if (full) begin
      chk(o[i][15:14] == eb, rq, "ba", 32'(o[i][15:14]), 32'(eb));
      chk(o[i][13:1] == ea, rq, "addr", 32'(o[i][13:1]), 32'(ea));
    end
  endtask

  task automatic run(int d, int abort_n);
    int last_n = (when(0,7) > when(1,7) ? when(0,7) : when(1,7)) + 4;
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++) idle_check(i, "R10");
    rst_n = 1'b1;
    for (int w = 0; w < d; w++) begin
      @(posedge clk); @(negedge clk);
      for (int i = 0; i < 2; i++) idle_check(i, "R1");
    end
    start = 1'b1;
    for (int n = 1; n <= last_n; n++) begin
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 2; i++) cycle_check(i, n);
      if (n == abort_n) begin
        rst_n = 1'b0;
        #1;
        for (int i = 0; i < 2; i++) idle_check(i, "R10");
        @(posedge clk); @(negedge clk);
        for (int i = 0; i < 2; i++) idle_check(i, "R10");
        return;
      end
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    run(0, 0);
    run(1, 0);
    run(3, 20);
    run(2, 0);
    run(0, 214);
    run(4, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule